// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This controller arbitrates a set of level-sensitive internal interrupt sources together with one 4-bit encoded external request. Every cycle it selects the winning request and registers it onto three outputs: a request flag, the winner's 4-bit level and its 12-bit event code. The CPU reads these outputs when it takes the interrupt. Exception entry is not part of this block.

Levels come from 16-bit priority registers. Each register holds four 4-bit fields, and field k of the whole bank sits at bits [4k+3:4k] of the concatenated registers. A field drives either one source or a whole group of related sources. A 32-bit mask register can be changed through two write addresses: one sets the bits written as 1 and the other clears them. Mask bit i blocks internal source i. The external request cannot be masked.

Internal sources and their fixed attributes (index: code, field): 0 first timer 0x400, f0; 1 second timer 0x420, f1; 2 third-timer underflow 0x440, f2; 3 third-timer capture 0x460, f2; 4 watchdog 0x560, f4; 5 refresh compare 0x580, f5; 6 refresh overflow 0x5A0, f5; 7 serial error 0x4E0, f6; 8 serial receive 0x500, f6; 9 serial transmit 0x520, f6; 10 serial end 0x540, f6; 11 port input 0x620, f8. Fields 3, 7, 9, 10 and 11 exist but drive nothing.

Top module: `grp_prio_intc`

## Requirements
- R1: While reset is held and right after it, irq_req, irq_level and irq_code are 0, every priority register reads 0 and the mask reads 0. Whenever irq_req is 0, irq_level and irq_code are also 0.
- R2: A write to word address r, for r below the number of priority registers (3), stores bits [15:0]. Reading that address returns the stored value with bits [31:16] at 0. Addresses 3, 6 and 7 read as 0.
- R3: A write to address 4 sets every mask bit whose write-data bit is 1 and leaves the other bits unchanged. Reading address 4 or 5 returns the full 32-bit mask.
- R4: A write to address 5 clears every mask bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: An internal source is never accepted while its mask bit is 1 or its priority field is 0. When accepted, its reported level is the field value (1..15).
- R6: All members of a group take their level from the same field. Rewriting that one field changes the level reported for every member of the group.
- R7: The candidate with the highest level wins. On equal levels the lower internal index wins, and an internal source beats the external request.
- R8: An external value n in 0..14 requests at level 15-n with code 0x200+0x20*n. The value 15 means no external request.
- R9: An accepted internal source reports the fixed code listed for its index. Every reported code is a multiple of 0x20 and at least 0x200.
- R10: The outputs reflect the inputs and register contents that were present at the previous rising clock edge. They do not change until that edge.
- R11: Sources are level-sensitive. A request stays reported for as long as its input is held, and it is withdrawn one cycle after the input drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 12 | Level requests from internal sources |
| ext_lvl | input | 4 | Encoded external request, 15 = none |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_level | output | 4 | Level of the winning request |
| irq_code | output | 12 | Event code of the winning request |

## Verification
The bench builds the block with its default parameters: three priority registers, twelve internal sources and a 32-bit mask. With these values every group is reachable, including the four-member serial group and the shared timer and refresh fields, and so are the unused fields. Random source patterns, external values and register writes then produce level ties across groups, as well as ties between internal sources and the external request. These ties bring the ordering rule into play more often than directed cases alone would.

// File: rtl/gpic_pkg.sv
package gpic_pkg;

    localparam int NUM_SRC        = 12;
    localparam int FIELD_W        = 4;
    localparam int FIELDS_PER_REG = 4;
    localparam int PRIO_REG_W     = FIELD_W * FIELDS_PER_REG;
    localparam int CODE_W         = 12;
    localparam int MASK_W         = 32;
    localparam int DATA_W         = 32;
    localparam int ADDR_W         = 3;

    localparam logic [ADDR_W-1:0] ADDR_MASK_SET = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_MASK_CLR = 3'd5;

    localparam logic [FIELD_W-1:0] EXT_IDLE = 4'hF;
    localparam logic [CODE_W-1:0]  EXT_BASE = 12'h200;

    typedef logic [FIELD_W-1:0] level_t;
    typedef logic [CODE_W-1:0]  code_t;

    typedef struct packed {
        logic   valid;
        level_t level;
        code_t  code;
    } cand_t;

    localparam cand_t CAND_NONE = '{valid: 1'b0, level: '0, code: '0};

    // Fixed event code of each internal source.
    function automatic code_t src_code(input int idx);
        case (idx)
            0:       return 12'h400;
            1:       return 12'h420;
            2:       return 12'h440;
            3:       return 12'h460;
            4:       return 12'h560;
            5:       return 12'h580;
            6:       return 12'h5A0;
            7:       return 12'h4E0;
            8:       return 12'h500;
            9:       return 12'h520;
            10:      return 12'h540;
            default: return 12'h620;
        endcase
    endfunction

    // Global priority field that drives each source; group members share one.
    function automatic int src_field(input int idx);
        case (idx)
            0:          return 0;
            1:          return 1;
            2, 3:       return 2;
            4:          return 4;
            5, 6:       return 5;
            7, 8, 9, 10: return 6;
            default:    return 8;
        endcase
    endfunction

    // Keep the incumbent unless the challenger is valid and strictly higher.
    function automatic cand_t pick(input cand_t inc, input cand_t chal);
        if (chal.valid && (!inc.valid || chal.level > inc.level))
            return chal;
        return inc;
    endfunction

endpackage

// File: rtl/gpic_regs.sv
module gpic_regs
    import gpic_pkg::*;
#(
    parameter int NUM_PRIO_REGS = 3
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 reg_we,
    input  logic [ADDR_W-1:0]                    reg_addr,
    input  logic [DATA_W-1:0]                    reg_wdata,
    output logic [DATA_W-1:0]                    reg_rdata,
    output logic [NUM_PRIO_REGS*PRIO_REG_W-1:0]  prio_flat,
    output logic [MASK_W-1:0]                    mask_vec
);

    logic [NUM_PRIO_REGS-1:0][PRIO_REG_W-1:0] prio_q;
    logic [MASK_W-1:0]                        mask_q;

    for (genvar r = 0; r < NUM_PRIO_REGS; r++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[r] <= '0;
            else if (reg_we && reg_addr == ADDR_W'(r))
                prio_q[r] <= reg_wdata[PRIO_REG_W-1:0];
        end
        assign prio_flat[r*PRIO_REG_W +: PRIO_REG_W] = prio_q[r];
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (reg_we && reg_addr == ADDR_MASK_SET)
            mask_q <= mask_q | reg_wdata[MASK_W-1:0];
        else if (reg_we && reg_addr == ADDR_MASK_CLR)
            mask_q <= mask_q & ~reg_wdata[MASK_W-1:0];
    end

    assign mask_vec = mask_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_MASK_SET || reg_addr == ADDR_MASK_CLR)
            reg_rdata[MASK_W-1:0] = mask_q;
        for (int r = 0; r < NUM_PRIO_REGS; r++)
            if (reg_addr == ADDR_W'(r))
                reg_rdata[PRIO_REG_W-1:0] = prio_q[r];
    end

endmodule

// File: rtl/gpic_ext_decode.sv
module gpic_ext_decode
    import gpic_pkg::*;
(
    input  logic [FIELD_W-1:0] ext_lvl,
    output cand_t              ext_cand
);

    always_comb begin
        ext_cand       = CAND_NONE;
        ext_cand.valid = (ext_lvl != EXT_IDLE);
        if (ext_cand.valid) begin
            ext_cand.level = EXT_IDLE - ext_lvl;
            ext_cand.code  = EXT_BASE + {3'b000, ext_lvl, 5'b00000};
        end
    end

endmodule

// File: rtl/gpic_arbiter.sv
module gpic_arbiter
    import gpic_pkg::*;
#(
    parameter int NUM_PRIO_REGS = 3
) (
    input  logic [NUM_SRC-1:0]                  src_req,
    input  logic [MASK_W-1:0]                   mask_vec,
    input  logic [NUM_PRIO_REGS*PRIO_REG_W-1:0] prio_flat,
    input  cand_t                               ext_cand,
    output cand_t                               winner
);

    cand_t chain [NUM_SRC+1];

    assign chain[0] = CAND_NONE;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int FLD = src_field(i);
        level_t lvl;
        cand_t  cand;
        assign lvl        = prio_flat[FLD*FIELD_W +: FIELD_W];
        assign cand.valid = src_req[i] && !mask_vec[i] && (lvl != '0);
        assign cand.level = lvl;
        assign cand.code  = src_code(i);
        // Strictly-higher replacement keeps the lower index on ties.
        assign chain[i+1] = pick(chain[i], cand);
    end

    // External input enters last, so it loses every tie.
    assign winner = pick(chain[NUM_SRC], ext_cand);

endmodule

// File: rtl/grp_prio_intc.sv
module grp_prio_intc
    import gpic_pkg::*;
#(
    parameter int NUM_PRIO_REGS = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    src_req,
    input  logic [FIELD_W-1:0]    ext_lvl,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  irq_req,
    output logic [FIELD_W-1:0]    irq_level,
    output logic [CODE_W-1:0]     irq_code
);

    logic [NUM_PRIO_REGS*PRIO_REG_W-1:0] prio_flat;
    logic [MASK_W-1:0]                   mask_vec;
    cand_t                               ext_cand;
    cand_t                               winner;

    gpic_regs #(.NUM_PRIO_REGS(NUM_PRIO_REGS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .prio_flat (prio_flat),
        .mask_vec  (mask_vec)
    );

    gpic_ext_decode u_ext (
        .ext_lvl  (ext_lvl),
        .ext_cand (ext_cand)
    );

    gpic_arbiter #(.NUM_PRIO_REGS(NUM_PRIO_REGS)) u_arb (
        .src_req   (src_req),
        .mask_vec  (mask_vec),
        .prio_flat (prio_flat),
        .ext_cand  (ext_cand),
        .winner    (winner)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_req   <= 1'b0;
            irq_level <= '0;
            irq_code  <= '0;
        end else begin
            irq_req   <= winner.valid;
            irq_level <= winner.valid ? winner.level : '0;
            irq_code  <= winner.valid ? winner.code  : '0;
        end
    end

endmodule

// File: rtl/grp_prio_intc_chk.sv
module grp_prio_intc_chk
    import gpic_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [NUM_SRC-1:0]  src_req,
    input logic [FIELD_W-1:0]  ext_lvl,
    input logic                reg_we,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [MASK_W-1:0]   mask_vec,
    input logic                irq_req,
    input logic [FIELD_W-1:0]  irq_level,
    input logic [CODE_W-1:0]   irq_code
);

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> (irq_level == '0 && irq_code == '0));

    p_level_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irq_level != '0);

    p_code_grid_r9: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_code[4:0] == 5'd0 && irq_code >= 12'h200));

    p_ext_only_r8: assert property (@(posedge clk) disable iff (rst)
        (src_req == '0 && ext_lvl != EXT_IDLE) |=>
            (irq_req && irq_level == 4'hF - $past(ext_lvl)
             && irq_code == 12'h200 + {3'b000, $past(ext_lvl), 5'b00000}));

    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (src_req == '0 && ext_lvl == EXT_IDLE) |=> !irq_req);

    p_mask_set_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_MASK_SET) |=>
            ((mask_vec & $past(reg_wdata)) == $past(reg_wdata)));

    p_mask_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_MASK_CLR) |=>
            ((mask_vec & $past(reg_wdata)) == '0));

endmodule

bind grp_prio_intc grp_prio_intc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_req   (src_req),
    .ext_lvl   (ext_lvl),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mask_vec  (mask_vec),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .irq_code  (irq_code)
);

// File: tb/grp_prio_intc_tb.sv
module grp_prio_intc_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] src_req;
    logic [3:0]  ext_lvl;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [3:0]  irq_level;
    logic [11:0] irq_code;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_prio [3];
    logic [31:0] m_mask;

    always #5 clk = ~clk;

    grp_prio_intc u_dut (
        .clk(clk), .rst(rst), .src_req(src_req), .ext_lvl(ext_lvl),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_level(irq_level),
        .irq_code(irq_code)
    );

    function automatic logic [11:0] b_code(input int i);
        logic [11:0] t [12] = '{12'h400, 12'h420, 12'h440, 12'h460, 12'h560,
                                12'h580, 12'h5A0, 12'h4E0, 12'h500, 12'h520,
                                12'h540, 12'h620};
        return t[i];
    endfunction

    function automatic int b_field(input int i);
        int t [12] = '{0, 1, 2, 2, 4, 5, 5, 6, 6, 6, 6, 8};
        return t[i];
    endfunction

    // Expected {req, level, code} from the bench's own register model.
    function automatic logic [16:0] b_expect(input logic [11:0] req, input logic [3:0] ext);
        logic        v = 1'b0;
        logic [3:0]  lv = 4'd0;
        logic [11:0] cd = 12'd0;
        for (int i = 0; i < 12; i++) begin
            int f = b_field(i);
            logic [3:0] p = m_prio[f / 4][(f % 4) * 4 +: 4];
            if (req[i] && !m_mask[i] && p != 0 && (!v || p > lv)) begin
                v = 1'b1; lv = p; cd = b_code(i);
            end
        end
        if (ext != 4'hF && (!v || (4'hF - ext) > lv)) begin
            v = 1'b1; lv = 4'hF - ext; cd = 12'h200 + 12'h20 * ext;
        end
        return {v, lv, cd};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model_write(input logic [2:0] a, input logic [31:0] d);
        if (a < 3'd3) m_prio[a] = d[15:0];
        else if (a == 3'd4) m_mask = m_mask | d;
        else if (a == 3'd5) m_mask = m_mask & ~d;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic out_chk(input string req);
        logic [16:0] e = b_expect(src_req, ext_lvl);
        chk(req, {15'd0, irq_req, irq_level, irq_code}, {15'd0, e});
    endtask

    task automatic drive_chk(input string req, input logic [11:0] s, input logic [3:0] x);
        src_req = s; ext_lvl = x;
        step();
        out_chk(req);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [16:0] e;
        void'($urandom(32'h5EED_0042));
        m_prio = '{16'h0, 16'h0, 16'h0};
        m_mask = 32'h0;
        rst = 1'b1; src_req = '0; ext_lvl = 4'hF;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) step();
        // R1: reset state, while held
        chk("R1 outputs in reset", {irq_req, irq_level, irq_code}, 17'd0);
        rst = 1'b0;
        step();
        chk("R1 outputs after reset", {irq_req, irq_level, irq_code}, 17'd0);
        rd_chk("R1 prio0 reset", 3'd0, 32'd0);
        rd_chk("R1 mask reset", 3'd4, 32'd0);

        // R2: 16-bit priority storage
        wr(3'd0, 32'hABCD_1234);
        rd_chk("R2 prio0 readback", 3'd0, 32'h0000_1234);
        rd_chk("R2 unused address", 3'd3, 32'd0);
        wr(3'd0, 32'h0);

        // R3 / R4: mask set and clear addresses
        wr(3'd4, 32'h0000_0005);
        wr(3'd4, 32'h8000_0002);
        rd_chk("R3 mask set accumulates", 3'd4, 32'h8000_0007);
        wr(3'd5, 32'h8000_0004);
        rd_chk("R4 mask clear", 3'd5, 32'h0000_0003);
        wr(3'd5, 32'hFFFF_FFFF);
        rd_chk("R4 mask clear all", 3'd4, 32'd0);

        // R5: priority zero never accepted
        drive_chk("R5 zero priority ignored", 12'h001, 4'hF);
        chk("R5 zero priority no req", {31'd0, irq_req}, 32'd0);

        // R6: group field drives all serial members (field 6 = reg1 bits 11:8)
        wr(3'd1, 32'h0000_0900);
        drive_chk("R6 group member rx", 12'h100, 4'hF);
        chk("R6 rx level", {28'd0, irq_level}, 32'd9);
        drive_chk("R6 group member end", 12'h400, 4'hF);
        wr(3'd1, 32'h0000_0300);
        step();
        out_chk("R6 group field rewrite");
        chk("R6 new level", {28'd0, irq_level}, 32'd3);

        // R5: masked source ignored, other still visible
        wr(3'd4, 32'h0000_0400);
        drive_chk("R5 masked source", 12'h400, 4'hF);
        chk("R5 masked no req", {31'd0, irq_req}, 32'd0);
        wr(3'd5, 32'h0000_0400);

        // R7: ties and ordering
        wr(3'd0, 32'h0000_0055);
        drive_chk("R7 tie lower index", 12'h003, 4'hF);
        chk("R7 tie code", {20'd0, irq_code}, 32'h400);
        drive_chk("R7 tie vs external", 12'h002, 4'd10);
        chk("R7 internal beats ext tie", {20'd0, irq_code}, 32'h420);
        drive_chk("R7 ext higher", 12'h003, 4'd9);
        chk("R7 ext wins", {20'd0, irq_code}, 32'h320);

        // R8: external decode
        drive_chk("R8 ext n=14", 12'h000, 4'd14);
        chk("R8 n=14 code", {16'd0, irq_level, irq_code}, {16'd0, 4'd1, 12'h3C0});
        drive_chk("R8 ext n=0", 12'h000, 4'd0);
        chk("R8 n=0 code", {16'd0, irq_level, irq_code}, {16'd0, 4'd15, 12'h200});
        drive_chk("R8 ext idle", 12'h000, 4'hF);
        chk("R8 idle no req", {31'd0, irq_req}, 32'd0);

        // R9: fixed code for watchdog (field 4 = reg1 bits 3:0)
        wr(3'd1, 32'h0000_030C);
        drive_chk("R9 watchdog code", 12'h010, 4'hF);
        chk("R9 watchdog 0x560", {20'd0, irq_code}, 32'h560);

        // R10: outputs change only at the next edge
        src_req = 12'h000; ext_lvl = 4'hF;
        step();
        src_req = 12'h001;
        #1;
        chk("R10 no change before edge", {31'd0, irq_req}, 32'd0);
        step();
        out_chk("R10 change after edge");
        chk("R10 req after edge", {31'd0, irq_req}, 32'd1);

        // R11: level-sensitive hold and withdrawal
        repeat (3) step();
        chk("R11 held request", {31'd0, irq_req}, 32'd1);
        drive_chk("R11 withdrawn", 12'h000, 4'hF);
        chk("R11 no req after drop", {31'd0, irq_req}, 32'd0);

        // R7 / R9: random mix
        for (int it = 0; it < 400; it++) begin
            logic [2:0] a;
            logic       w;
            case ($urandom % 5)
                0: a = 3'd0; 1: a = 3'd1; 2: a = 3'd2; 3: a = 3'd4; default: a = 3'd5;
            endcase
            w = ($urandom % 4) == 0;
            src_req = 12'($urandom);
            ext_lvl = 4'($urandom);
            e = b_expect(src_req, ext_lvl);
            reg_we = w; reg_addr = a; reg_wdata = $urandom;
            step();
            reg_we = 1'b0;
            chk("R7 random arbitration", {15'd0, irq_req, irq_level, irq_code}, {15'd0, e});
            if (w) model_write(a, reg_wdata);
        end

        summary();
    end

endmodule